// File: doc/BRIEF.md
# Miss-Triggered Next-Line and Stride Prefetcher

This block sits beside a second-level cache and listens to its demand read misses. Every accepted miss carries a 64-bit byte address. The block removes the offset bits to form a block address, which is the tag and the index joined together. The size of the offset comes from a block-size exponent. The block then proposes one candidate block, either the next sequential block or the block one stride further on. The stride is the distance between the two most recent miss block addresses.

A candidate is never sent straight away. The block first waits for the cache to report that the demand fill has finished. It then asks the cache, through a lookup request and response, whether the candidate is already resident. The prefetch is issued only when the lookup reports the candidate absent, and each issued prefetch adds one to a running count. Only one candidate is handled at a time, so the miss input is held off until the current one has been resolved.

Top module: `prefetch_engine`

## Requirements
- R1: After reset, miss_ready is 1, lookup_valid is 0, pf_valid is 0 and pf_count is 0.
- R2: The block address is the byte address shifted right by blk_shift bits, where blk_shift is 5, 6 or 7. Candidates and lookups are expressed as block addresses.
- R3: With pf_mode = 1 (next-line), a miss on block X gives the candidate X+1.
- R4: With pf_mode = 2 (stride), a miss on block Y gives the candidate Y+(Y−X), where X is the block of the previous accepted miss. Every accepted miss records its block, whatever the mode. The first miss after reset has no previous block and gives no candidate.
- R5: In stride mode, a miss on the same block as the previous miss gives no candidate. In that case no lookup is raised and no prefetch is issued.
- R6: pf_mode = 0 (off) and pf_mode = 3 (reserved) produce no lookup and no prefetch, and miss_ready stays 1.
- R7: lookup_valid rises only in the cycle after fill_done is seen for the pending miss. It then stays high until lookup_resp_valid arrives.
- R8: When the lookup response reports the block as present (lookup_hit = 1), no prefetch is issued and pf_count keeps its value.
- R9: When the response reports the block as absent, pf_valid is high for exactly one cycle, starting one cycle after the response. In that cycle pf_blk equals the candidate, and pf_count has grown by one in the same cycle.
- R10: miss_ready is low from the cycle after a miss with a candidate is accepted until the cycle after its lookup response. This keeps at most one candidate outstanding.
- R11: Stride arithmetic is two's complement, modulo 2^64, on block addresses. A backward stride therefore gives a lower candidate, and that candidate may wrap around below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Demand read miss offered |
| miss_ready | output | 1 | Block can accept a miss |
| miss_addr | input | 64 | Byte address of the miss |
| blk_shift | input | 3 | Block-size exponent (5..7) |
| pf_mode | input | 2 | 0 off, 1 next-line, 2 stride, 3 reserved (off) |
| fill_done | input | 1 | Demand block has been inserted |
| lookup_valid | output | 1 | Presence check request, held until response |
| lookup_blk | output | 64 | Block address being checked |
| lookup_resp_valid | input | 1 | Presence check answer valid |
| lookup_hit | input | 1 | Block already resident |
| pf_valid | output | 1 | Prefetch issued (one-cycle pulse) |
| pf_blk | output | 64 | Block address to prefetch |
| pf_count | output | 16 | Number of prefetches issued |

## Verification
Next-line misses are sent with all three block sizes. Because the low offset bits are set, a wrong shift amount shows up as a wrong lookup address. Stride sequences are run from a fresh reset and cover the first miss, a forward step, a backward step, a repeated block and a step that wraps below zero. These separate the recorded-previous-block logic from the subtraction and the zero-stride filter. Each candidate case is paired with both a present and an absent lookup answer, so the skip path and the issue path are told apart. Misses in modes 0 and 3 are interleaved with the others: they must leave the handshake idle, yet they still update the stride history.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned PF_ADDR_W  = 64;
  localparam int unsigned PF_SHIFT_W = 3;

  typedef logic [PF_ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    PF_OFF    = 2'd0,
    PF_NEXT   = 2'd1,
    PF_STRIDE = 2'd2,
    PF_RSVD   = 2'd3
  } pf_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_FILL = 2'd1,
    S_LOOK = 2'd2
  } pf_state_e;

  // byte address -> block address (tag and index)
  function automatic addr_t blk_of(addr_t a, logic [PF_SHIFT_W-1:0] sh);
    return a >> sh;
  endfunction

  function automatic addr_t next_of(addr_t b);
    return b + addr_t'(1);
  endfunction

  // cur + (cur - prev), written as 2*cur - prev, modulo 2^64
  function automatic addr_t stride_of(addr_t cur, addr_t prev);
    return (cur << 1) - prev;
  endfunction
endpackage

// File: rtl/pf_target.sv
module pf_target
  import pf_pkg::*;
#(
  parameter int unsigned SHIFT_MIN = 5,
  parameter int unsigned SHIFT_MAX = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire,
  input  addr_t                 miss_addr,
  input  logic [PF_SHIFT_W-1:0] shift,
  input  logic [1:0]            mode,
  output logic                  want,
  output addr_t                 cand
);
  addr_t blk;
  addr_t last_blk;
  logic  last_vld;

  assign blk = blk_of(miss_addr, shift);

  always_comb begin
    want = 1'b0;
    cand = blk;
    case (pf_mode_e'(mode))
      PF_NEXT: begin
        want = 1'b1;
        cand = next_of(blk);
      end
      PF_STRIDE: begin
        want = last_vld && (blk != last_blk);
        cand = stride_of(blk, last_blk);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_blk <= '0;
      last_vld <= 1'b0;
    end else if (fire) begin
      last_blk <= blk;
      last_vld <= 1'b1;
    end
  end

  p_shift_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (32'(shift) >= SHIFT_MIN && 32'(shift) <= SHIFT_MAX));

  // R5: a repeated block never starts a stride candidate
  p_zero_stride_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pf_mode_e'(mode) == PF_STRIDE && last_vld && blk == last_blk) |-> !want);
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  miss_valid,
  output logic  miss_ready,
  output logic  fire,
  input  logic  want,
  input  addr_t cand,
  input  logic  fill_done,
  output logic  lk_valid,
  output addr_t lk_addr,
  input  logic  lk_resp_valid,
  input  logic  lk_hit,
  output logic  pf_fire,
  output logic  pf_valid,
  output addr_t pf_addr
);
  pf_state_e state;
  addr_t     tgt_q;
  logic      resp_take;

  assign miss_ready = (state == S_IDLE);
  assign fire       = miss_valid && miss_ready;
  assign lk_valid   = (state == S_LOOK);
  assign lk_addr    = tgt_q;
  assign resp_take  = lk_valid && lk_resp_valid;
  assign pf_fire    = resp_take && !lk_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tgt_q    <= '0;
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else begin
      pf_valid <= pf_fire;
      if (pf_fire) pf_addr <= tgt_q;
      case (state)
        S_IDLE: if (fire && want) begin
          state <= S_FILL;
          tgt_q <= cand;
        end
        S_FILL: if (fill_done) state <= S_LOOK;
        S_LOOK: if (lk_resp_valid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_lookup_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lk_valid) |-> $past(fill_done));

  p_lookup_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_resp_valid) |=> lk_valid);

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> !miss_ready);

  p_pf_after_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(lk_valid && lk_resp_valid && !lk_hit));

  p_pf_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |=> !pf_valid);
endmodule

// File: rtl/pf_counter.sv
module pf_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (bump) count <= count + CNT_W'(1);
  end

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/prefetch_engine.sv
module prefetch_engine
  import pf_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SHIFT_MIN = 5,
  parameter int unsigned SHIFT_MAX = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  miss_valid,
  output logic                  miss_ready,
  input  logic [PF_ADDR_W-1:0]  miss_addr,
  input  logic [PF_SHIFT_W-1:0] blk_shift,
  input  logic [1:0]            pf_mode,
  input  logic                  fill_done,
  output logic                  lookup_valid,
  output logic [PF_ADDR_W-1:0]  lookup_blk,
  input  logic                  lookup_resp_valid,
  input  logic                  lookup_hit,
  output logic                  pf_valid,
  output logic [PF_ADDR_W-1:0]  pf_blk,
  output logic [CNT_W-1:0]      pf_count
);
  // named internal events
  logic  miss_fire;
  logic  cand_want;
  addr_t cand_blk;
  logic  pf_fire;

  pf_target #(.SHIFT_MIN(SHIFT_MIN), .SHIFT_MAX(SHIFT_MAX)) u_target (
    .clk(clk), .rst_n(rst_n), .fire(miss_fire), .miss_addr(miss_addr),
    .shift(blk_shift), .mode(pf_mode), .want(cand_want), .cand(cand_blk)
  );

  pf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .fire(miss_fire), .want(cand_want), .cand(cand_blk), .fill_done(fill_done),
    .lk_valid(lookup_valid), .lk_addr(lookup_blk),
    .lk_resp_valid(lookup_resp_valid), .lk_hit(lookup_hit),
    .pf_fire(pf_fire), .pf_valid(pf_valid), .pf_addr(pf_blk)
  );

  pf_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .bump(pf_fire), .count(pf_count)
  );

  p_count_with_pf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_count != $past(pf_count)) |-> pf_valid);

  p_hit_no_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && lookup_resp_valid && lookup_hit) |=> (!pf_valid && $stable(pf_count)));
endmodule

// File: tb/prefetch_engine_tb_top.sv
module prefetch_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [63:0] miss_addr = '0;
  logic [2:0]  blk_shift = 3'd6;
  logic [1:0]  pf_mode = 2'd0;
  logic        fill_done = 1'b0;
  logic        lookup_valid;
  logic [63:0] lookup_blk;
  logic        lookup_resp_valid = 1'b0;
  logic        lookup_hit = 1'b0;
  logic        pf_valid;
  logic [63:0] pf_blk;
  logic [15:0] pf_count;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [63:0] blk; logic [15:0] cnt; } exp_t;
  exp_t sb_q[$];

  // bench model state
  logic [63:0] m_last = '0;
  bit          m_last_vld = 0;
  logic [15:0] m_cnt = '0;

  always #2 clk = ~clk;  // 250 MHz

  prefetch_engine dut_i (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .blk_shift(blk_shift), .pf_mode(pf_mode),
    .fill_done(fill_done), .lookup_valid(lookup_valid), .lookup_blk(lookup_blk),
    .lookup_resp_valid(lookup_resp_valid), .lookup_hit(lookup_hit),
    .pf_valid(pf_valid), .pf_blk(pf_blk), .pf_count(pf_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every issued prefetch
  always @(negedge clk) begin
    if (rst_n && pf_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected prefetch", pf_blk, 64'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(pf_blk == e.blk, "R9", "prefetch block", pf_blk, e.blk);
        chk(pf_count == e.cnt, "R9", "prefetch count", 64'(pf_count), 64'(e.cnt));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_last = '0; m_last_vld = 0; m_cnt = '0;
    @(negedge clk);
    chk(miss_ready == 1'b1, "R1", "miss_ready after reset", 64'(miss_ready), 64'd1);
    chk(lookup_valid == 1'b0, "R1", "lookup_valid after reset", 64'(lookup_valid), 64'd0);
    chk(pf_valid == 1'b0, "R1", "pf_valid after reset", 64'(pf_valid), 64'd0);
    chk(pf_count == 16'd0, "R1", "pf_count after reset", 64'(pf_count), 64'd0);
  endtask

  task automatic do_miss(input logic [63:0] a, input logic [2:0] sh, input logic [1:0] md,
                         input bit hit, input string req);
    logic [63:0] blk, cand;
    bit want;
    blk  = a / (64'd1 << sh);
    want = 0;
    cand = '0;
    if (md == 2'd1) begin
      want = 1; cand = blk + 64'd1;
    end else if (md == 2'd2) begin
      want = m_last_vld && (blk != m_last);
      cand = blk + (blk - m_last);
    end
    m_last = blk; m_last_vld = 1;

    chk(miss_ready == 1'b1, "R10", "ready before miss", 64'(miss_ready), 64'd1);
    miss_addr = a; blk_shift = sh; pf_mode = md; miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    if (want) begin
      for (int i = 0; i < 3; i++) begin
        chk(lookup_valid == 1'b0, "R7", "lookup before fill", 64'(lookup_valid), 64'd0);
        chk(miss_ready == 1'b0, "R10", "ready while pending", 64'(miss_ready), 64'd0);
        @(negedge clk);
      end
      fill_done = 1'b1;
      @(negedge clk);
      fill_done = 1'b0;
      chk(lookup_valid == 1'b1, "R7", "lookup after fill", 64'(lookup_valid), 64'd1);
      chk(lookup_blk == cand, req, "lookup block", lookup_blk, cand);
      @(negedge clk);
      chk(lookup_valid == 1'b1, "R7", "lookup held", 64'(lookup_valid), 64'd1);
      lookup_resp_valid = 1'b1; lookup_hit = hit;
      if (!hit) begin
        exp_t e;
        m_cnt = m_cnt + 16'd1;
        e.blk = cand; e.cnt = m_cnt;
        sb_q.push_back(e);
      end
      @(negedge clk);
      lookup_resp_valid = 1'b0; lookup_hit = 1'b0;
      chk(pf_valid == !hit, hit ? "R8" : "R9", "prefetch issued", 64'(pf_valid), 64'(!hit));
      chk(pf_count == m_cnt, hit ? "R8" : "R9", "count after response", 64'(pf_count), 64'(m_cnt));
      chk(miss_ready == 1'b1, "R10", "ready after response", 64'(miss_ready), 64'd1);
      @(negedge clk);
    end else begin
      chk(lookup_valid == 1'b0, req, "no lookup", 64'(lookup_valid), 64'd0);
      chk(miss_ready == 1'b1, req, "still ready", 64'(miss_ready), 64'd1);
      @(negedge clk);
      chk(pf_valid == 1'b0, req, "no prefetch", 64'(pf_valid), 64'd0);
      chk(pf_count == m_cnt, req, "count unchanged", 64'(pf_count), 64'(m_cnt));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // next-line, three block sizes, offset bits set
    do_miss(64'h1000, 3'd6, 2'd1, 0, "R3");
    do_miss(64'h101f, 3'd5, 2'd1, 0, "R2");
    do_miss(64'h107f, 3'd7, 2'd1, 0, "R2");
    do_miss(64'h2040, 3'd6, 2'd1, 1, "R8");
    do_miss(64'h5000, 3'd6, 2'd0, 0, "R6");
    do_miss(64'h5000, 3'd6, 2'd3, 0, "R6");
    // stride from a fresh reset
    do_reset();
    do_miss(64'h0400, 3'd6, 2'd2, 0, "R4");   // first miss: none
    do_miss(64'h0540, 3'd6, 2'd2, 0, "R4");   // 0x15 after 0x10 -> 0x1a
    do_miss(64'h04c0, 3'd6, 2'd2, 0, "R11");  // back to 0x13 -> 0x11
    do_miss(64'h04c0, 3'd6, 2'd2, 0, "R5");   // same block
    do_miss(64'h0600, 3'd6, 2'd2, 1, "R8");   // 0x18 -> 0x1d, resident
    do_miss(64'h0040, 3'd6, 2'd0, 0, "R6");   // off mode, still recorded
    do_miss(64'h0640, 3'd6, 2'd2, 0, "R4");   // 0x19 after 0x01 -> 0x31
    do_miss(64'h0040, 3'd6, 2'd2, 0, "R11");  // 0x01 after 0x19 -> wraps
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R9", "scoreboard drained", 64'(sb_q.size()), 64'd0);
    chk(pf_count == m_cnt, "R9", "final count", 64'(pf_count), 64'(m_cnt));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule